// File: doc/BRIEF.md
# Timer Tick Source Selector and Prescaler

This block makes the count-enable tick for a timer. A one-bit source select chooses between the system clock itself, which gives a tick on every cycle, and a slow alternate clock of about 32 kHz. The alternate clock never drives a flop's clock pin. It is treated as data: it passes through a two-flop synchronizer in the system clock domain, and each rising edge of the synchronized level becomes a single-cycle enable.

The chosen tick stream then goes through a prescaler. A 3-bit divide field gives a division factor of two raised to its value, from 1 up to 128. The output is a registered enable that is high for one system-clock cycle per prescaled tick. When the select bit or the divide field changes, the prescaler starts again from zero, so the first pulse under the new setting comes one full new period after the change.

Top module: `tick_source_prescaler`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `tick_o` is low in the cycle after that edge.
- R2: With `src_sel_i` = 0 (system clock source) and `div_sel_i` = 0 held steady, `tick_o` is high on every cycle.
- R3: With `src_sel_i` = 0 and `div_sel_i` = d held steady, `tick_o` pulses once every 2^d cycles. Each pulse is one cycle wide when d is not 0.
- R4: If `src_sel_i` or `div_sel_i` differs at edge E from its value at the edge before, `tick_o` is low in the cycle after E. The prescale count restarts from zero, so the first pulse comes in the cycle after edge E + 2^d, where d is the new `div_sel_i`.
- R5: With `src_sel_i` = 1 (alternate source) and `div_sel_i` = 0, each low-to-high change of `alt_clk_i` gives exactly one `tick_o` pulse. If the change is first sampled at edge k, the pulse comes in the cycle after edge k+2. Falling changes and a level held high give no pulse.
- R6: An `alt_clk_i` that runs at one quarter of the system clock rate (two cycles high, two cycles low) has every rising edge counted.
- R7: With `src_sel_i` = 1 and `div_sel_i` = d, `tick_o` pulses once per 2^d rising edges of `alt_clk_i`.
- R8: With `src_sel_i` = 0, activity on `alt_clk_i` has no effect on `tick_o`.
- R9: With `src_sel_i` = 1 and `alt_clk_i` constant, `tick_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_clk_i | input | 1 | Slow alternate clock, sampled as data |
| src_sel_i | input | 1 | Tick source: 0 selects the system clock, 1 selects the alternate clock |
| div_sel_i | input | DIV_W (3) | Prescale exponent d; the division factor is 2^d |
| tick_o | output | 1 | One-cycle count-enable pulse |

## Verification
The bench goes after the edges of the prescaler and the sampler. It steps through every divide value in a shuffled order. If the count bound were off by one, or the factor linear instead of a power of two, the pulse spacing or the first-pulse cycle would come out wrong. A change made in the middle of a period catches a counter that keeps its old phase, since that counter would fire early. The alternate clock is driven at exactly the quarter-rate limit, held high for a long stretch, and toggled while the system source is selected. These catch a sampler that drops edges, counts levels or falling edges, has the wrong latency, or lets the unselected source leak through.

// File: rtl/tsp_pkg.sv
// Package: shared types and defaults for the timer tick source/prescaler.
// Assumes: nothing beyond IEEE 1800-2017.
package tsp_pkg;

    // Encoding of the tick source select bit.
    typedef enum logic {
        SRC_SYS = 1'b0,
        SRC_ALT = 1'b1
    } tick_src_e;

    // Default width of the prescale exponent field.
    localparam int unsigned DIV_W_DEFAULT = 3;

    // Default depth of the alternate-clock synchronizer.
    localparam int unsigned SYNC_DEFAULT = 2;

endpackage

// File: rtl/tsp_alt_sampler.sv
// Module: tsp_alt_sampler
// Brings a slow, asynchronous clock-like signal into the system clock
// domain as data and turns each rising edge into a one-cycle enable.
// Assumes: the input stays high and low for at least two system cycles each
// (one quarter of the system rate at most); SYNC_STAGES >= 2.
module tsp_alt_sampler #(
    parameter int unsigned SYNC_STAGES = tsp_pkg::SYNC_DEFAULT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    // Synchronizer chain: one flop per stage, stage 0 takes the raw input.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the asynchronous level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= async_i;
            end
        end else begin : g_next
            // Pass the level one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    // Remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[SYNC_STAGES-1];
    end

    // Rising edge of the synchronized level, one cycle wide.
    assign rise_o = chain_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/tsp_cfg_watch.sv
// Module: tsp_cfg_watch
// Keeps a copy of the source select and divide field from the previous edge
// and flags any difference so the prescaler can restart.
// Assumes: the copy also tracks the inputs during reset, so the first edge
// after reset compares against the value seen during reset.
module tsp_cfg_watch #(
    parameter int unsigned DIV_W = tsp_pkg::DIV_W_DEFAULT
) (
    input  logic             clk,
    input  logic             sel_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             restart_o
);

    localparam int unsigned CFG_W = DIV_W + 1;

    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;

    assign cfg_now = {sel_i, div_i};

    // Shadow of the configuration, loaded on every edge including reset.
    always_ff @(posedge clk) begin
        cfg_q <= cfg_now;
    end

    // Any field differing from the previous edge requests a restart.
    assign restart_o = (cfg_now != cfg_q);

endmodule

// File: rtl/tsp_div_counter.sv
// Module: tsp_div_counter
// Power-of-two prescaler: counts input steps and emits a registered
// one-cycle pulse on every 2^div_i-th step. A restart request clears the
// count and suppresses the pulse for that cycle.
// Assumes: div_i is stable whenever restart_i is low.
module tsp_div_counter #(
    parameter int unsigned DIV_W = tsp_pkg::DIV_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    localparam int unsigned CNT_W = (1 << DIV_W) - 1;

    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_q;
    logic             at_limit;
    logic             tick_q;

    // Terminal count for the selected exponent: 2^d - 1.
    always_comb begin
        span  = {{CNT_W{1'b0}}, 1'b1} << div_i;
        limit = span[CNT_W-1:0] - CNT_W'(1);
    end

    assign at_limit = (cnt_q == limit);

    // Step counter and registered output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (restart_i) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= step_i & at_limit;
            if (step_i) begin
                cnt_q <= at_limit ? '0 : cnt_q + CNT_W'(1);
            end
        end
    end

    assign tick_o = tick_q;

endmodule

// File: rtl/tick_source_prescaler.sv
// Module: tick_source_prescaler (top)
// Picks the timer tick source (every system cycle, or rising edges of a
// slow alternate clock sampled as data) and divides it by 2^div_sel_i.
// Assumes: alt_clk_i runs at no more than a quarter of the clock rate.
module tick_source_prescaler #(
    parameter int unsigned DIV_W       = tsp_pkg::DIV_W_DEFAULT,
    parameter int unsigned SYNC_STAGES = tsp_pkg::SYNC_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alt_clk_i,
    input  logic             src_sel_i,
    input  logic [DIV_W-1:0] div_sel_i,
    output logic             tick_o
);

    logic alt_rise;
    logic src_step;
    logic restart;

    tsp_alt_sampler #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (alt_clk_i),
        .rise_o  (alt_rise)
    );

    // Source mux: system source steps on every cycle.
    always_comb begin
        if (tsp_pkg::tick_src_e'(src_sel_i) == tsp_pkg::SRC_ALT) src_step = alt_rise;
        else                                                     src_step = 1'b1;
    end

    tsp_cfg_watch #(
        .DIV_W(DIV_W)
    ) u_watch (
        .clk       (clk),
        .sel_i     (src_sel_i),
        .div_i     (div_sel_i),
        .restart_o (restart)
    );

    tsp_div_counter #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (src_step),
        .restart_i (restart),
        .div_i     (div_sel_i),
        .tick_o    (tick_o)
    );

endmodule

// File: rtl/tick_source_prescaler_chk.sv
// Module: tick_source_prescaler_chk
// Port-level temporal checks for tick_source_prescaler, bound to the top.
// Assumes: same parameters as the bound instance.
module tick_source_prescaler_chk #(
    parameter int unsigned DIV_W = tsp_pkg::DIV_W_DEFAULT
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alt_clk_i,
    input logic             src_sel_i,
    input logic [DIV_W-1:0] div_sel_i,
    input logic             tick_o
);

    logic [2:0] age_q;

    // Edges seen since reset release, saturating at 7.
    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= 3'd0;
        else if (age_q != 3'd7)  age_q <= age_q + 3'd1;
    end

    AST_QUIET_IN_RESET: assert property (@(posedge clk)
        !rst_n |=> !tick_o); // R1

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_sel_i && div_sel_i == '0 && $stable(src_sel_i) && $stable(div_sel_i))
        |=> tick_o); // R2

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_sel_i != '0 && $stable(div_sel_i) && $stable(src_sel_i))
        |=> !tick_o); // R3

    AST_CHANGE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(src_sel_i) || !$stable(div_sel_i)) |=> !tick_o); // R4

    AST_ALT_EDGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd4 && tick_o && $past(src_sel_i))
        |-> ($past(alt_clk_i, 3) && !$past(alt_clk_i, 4))); // R5

endmodule

bind tick_source_prescaler tick_source_prescaler_chk #(
    .DIV_W(DIV_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .alt_clk_i (alt_clk_i),
    .src_sel_i (src_sel_i),
    .div_sel_i (div_sel_i),
    .tick_o    (tick_o)
);

// File: tb/tick_source_prescaler_test.sv
`timescale 1ns/1ps
// Bench: tick_source_prescaler_test
// Table-driven spacing checks for every divide value, then directed tests
// for reset, restart, the alternate source and its quarter-rate limit.
module tick_source_prescaler_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       alt_clk;
    logic       src_sel;
    logic [2:0] div_sel;
    logic       tick;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    bit count_en = 0;
    bit done = 0;

    // Table entries: {divide exponent, expected spacing in cycles}.
    localparam logic [10:0] VEC_TAB [0:7] = '{
        {3'd3, 8'd8},  {3'd0, 8'd1},   {3'd7, 8'd128}, {3'd1, 8'd2},
        {3'd5, 8'd32}, {3'd2, 8'd4},   {3'd6, 8'd64},  {3'd4, 8'd16}
    };

    tick_source_prescaler uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .alt_clk_i (alt_clk),
        .src_sel_i (src_sel),
        .div_sel_i (div_sel),
        .tick_o    (tick)
    );

    // 200 MHz system clock.
    always #2.5 clk = ~clk;

    // Pulse counter sampled away from the active edge.
    always @(negedge clk) begin
        if (count_en && tick === 1'b1) tick_cnt <= tick_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance n edges and land 1 ns after the last one.
    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Apply a setting at posedge+1 and compare every sample against the
    // restart timing: pulse at sample i when i > 1 and (i-1) % per == 0.
    task automatic measure(input logic s, input logic [2:0] d, input int per, input string req);
        bit ok;
        int bad_i;
        int bad_got;
        int bad_exp;
        ok = 1; bad_i = -1; bad_got = 0; bad_exp = 0;
        src_sel = s;
        div_sel = d;
        for (int i = 0; i <= 1 + 3 * per; i++) begin
            @(negedge clk);
            if (i >= 1) begin
                bit e;
                e = (i > 1) && (((i - 1) % per) == 0);
                if (tick !== e && ok) begin
                    ok = 0; bad_i = i; bad_got = int'(tick); bad_exp = int'(e);
                end
            end
        end
        @(posedge clk);
        #1;
        check(ok, $sformatf("%s (d=%0d, sample %0d)", req, d, bad_i), bad_got, bad_exp);
    endtask

    // Drive n rising edges on the alternate clock, half cycles high and low.
    task automatic alt_pulses(input int n, input int half);
        for (int r = 0; r < n; r++) begin
            alt_clk = 1'b1;
            cyc(half);
            alt_clk = 1'b0;
            cyc(half);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; alt_clk = 1'b0; src_sel = 1'b0; div_sel = 3'd0;
        cyc(4);

        // R1: output low while reset is held.
        @(negedge clk);
        check(tick === 1'b0, "R1 reset state", int'(tick), 0);
        @(posedge clk); #1;

        // R2: release with system source and divide 0, high every cycle.
        rst_n = 1'b1;
        begin
            bit ok;
            ok = 1;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (i >= 1 && tick !== 1'b1) ok = 0;
            end
            check(ok, "R2 full rate after reset", int'(tick), 1);
        end
        @(posedge clk); #1;

        // R1: reset asserted in the middle of a full-rate run.
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(tick === 1'b0, "R1 mid-run reset", int'(tick), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        cyc(3);

        // R3/R4: table walk over every divide value.
        for (int v = 0; v < 8; v++) begin
            measure(1'b0, VEC_TAB[v][10:8], int'(VEC_TAB[v][7:0]), "R3 spacing");
        end

        // R4: change in the middle of a period restarts the count.
        div_sel = 3'd4;
        cyc(5);
        measure(1'b0, 3'd3, 8, "R4 mid-period restart");

        // Switch to the alternate source, divide 0.
        src_sel = 1'b1; div_sel = 3'd0;
        cyc(6);

        // R9: alternate clock held low gives no pulse.
        tick_cnt = 0; count_en = 1;
        cyc(30);
        count_en = 0;
        check(tick_cnt == 0, "R9 idle alternate", tick_cnt, 0);

        // R5: latency from a rising change to the pulse.
        begin
            logic s2;
            logic s3;
            alt_clk = 1'b1;
            @(negedge clk);
            @(negedge clk);
            @(negedge clk); s2 = tick;
            @(negedge clk); s3 = tick;
            check(s2 === 1'b0, "R5 latency, no early pulse", int'(s2), 0);
            check(s3 === 1'b1, "R5 latency, pulse after third edge", int'(s3), 1);
            @(posedge clk); #1;
        end

        // R5: a long high level counts once; the fall counts nothing.
        tick_cnt = 0; count_en = 1;
        cyc(30);
        check(tick_cnt == 0, "R5 held high gives no extra pulse", tick_cnt, 0);
        alt_clk = 1'b0;
        cyc(30);
        count_en = 0;
        check(tick_cnt == 0, "R5 falling edge not counted", tick_cnt, 0);

        // R6: quarter-rate alternate clock, every edge counted.
        tick_cnt = 0; count_en = 1;
        alt_pulses(40, 2);
        cyc(6);
        count_en = 0;
        check(tick_cnt == 40, "R6 quarter rate edges", tick_cnt, 40);

        // R7: alternate source divided by 4.
        div_sel = 3'd2;
        cyc(4);
        tick_cnt = 0; count_en = 1;
        alt_pulses(40, 2);
        cyc(6);
        count_en = 0;
        check(tick_cnt == 10, "R7 alternate divided by 4", tick_cnt, 10);

        // R4: changing only the source bit restarts the count.
        measure(1'b0, 3'd2, 4, "R4 source change restart");

        // R8: alternate activity ignored under the system source.
        fork
            measure(1'b0, 3'd3, 8, "R8 alternate ignored");
            begin
                for (int k = 0; k < 26; k++) begin
                    alt_clk = ~alt_clk;
                    cyc(1);
                end
                alt_clk = 1'b0;
            end
        join

        done = 1;
        summary();
        $finish;
    end

endmodule